// File: doc/BRIEF.md
# Gate-Driven Capture Packetizer

This block turns gated bursts of converter samples into self-describing transfers. A source selector picks one of four converter channels or an internal ramp source. A transfer opens when the acquisition gate rises and closes when it falls, so its length is set by the gate and never programmed in advance. Accepted samples go straight to a downstream buffer over a valid/ready stream. A four-word record with a sync marker, the source ID, a 64-bit sample-accurate timestamp of the first sample and the sample count follows the data. In header mode the record is instead presented whole on a side port for one cycle, and a later stage patches it into a reserved header slot.

Transfers are described by a small on-chip table of linked descriptors. Each descriptor holds a maximum length and the index of the next descriptor. When a transfer closes, the block moves to the linked entry. If the gate outlasts the maximum length, the transfer is cut short, marked as truncated, and capture resumes under the next descriptor.

Stream rules: a word is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. The block has a single output holding slot. A gated sample that finds the slot still full is discarded rather than stalling the converter, and the sticky `overflow` flag is set.

Top module: `gate_capture_packer`

## Requirements
- R1: `src_sel` values 0 to 3 pick converter lane n (`ch_data[32n+31:32n]`), and any value of 4 or more picks the test ramp, whose word equals the low 32 bits of the sample's index. The selection is latched in the cycle the transfer opens, so later changes to `src_sel` have no effect on that transfer.
- R2: A cycle with `gate` and `smp_en` both high is a gated sample. A transfer opens in the first cycle `gate` is high while idle, and it also takes that cycle's sample. It closes in the first later cycle with `gate` low. Accepted samples leave in arrival order.
- R3: In trailer mode (`hdr_mode`=0, sampled at close), four record words follow the data: word0 = {8'hC5, 7'b0, trunc at bit 16, source ID in bits 15:0}, word1 = timestamp bits 31:0, word2 = timestamp bits 63:32, word3 = sample count. `out_last` is high only with word3.
- R4: The timestamp is the index of the first sample slot of the transfer: the number of `smp_en` cycles between reset release and the opening cycle.
- R5: The count is the number of samples delivered in the transfer. A gate that sees no sample still yields a record with count 0.
- R6: If the count reaches the descriptor's maximum length while the gate is still high, the transfer closes with trunc=1. Gated samples arriving from that closing cycle until the record has been sent are dropped and set `overflow`, and the next descriptor then opens a new transfer. A gate falling in the same cycle takes priority and gives trunc=0.
- R7: `cur_desc` is 0 after reset and moves to the current descriptor's next link once the record of each transfer has been issued. After reset, entry i has maximum length 16'hFFFF and next link (i+1) mod 4. A write through the `desc_w*` port replaces an entry.
- R8: A gated sample that meets a full output slot is dropped and sets `overflow`, which stays high until reset. A stalled word holds steady.
- R9: In header mode (`hdr_mode`=1), the record is not sent in the stream. Instead `meta_valid` pulses for one cycle with `meta_rec` = {word3, word2, word1, word0}.
- R10: During and after reset, `out_valid`, `out_last`, `meta_valid` and `overflow` are low and `cur_desc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | A new sample is present on all lanes this cycle |
| ch_data | input | 128 | Four packed 32-bit converter lanes |
| src_sel | input | 3 | Source select: 0-3 lanes, 4+ test ramp |
| gate | input | 1 | Acquisition gate |
| hdr_mode | input | 1 | 1: record on side port; 0: record as stream trailer |
| desc_we | input | 1 | Descriptor write strobe |
| desc_waddr | input | 2 | Descriptor entry to write |
| desc_wlen | input | 16 | Maximum length for the entry |
| desc_wnext | input | 2 | Next link for the entry |
| out_data | output | 32 | Stream word |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Downstream can take a word |
| out_last | output | 1 | Last word of a trailer record |
| meta_valid | output | 1 | One-cycle strobe for a header-mode record |
| meta_rec | output | 128 | Header-mode record, word0 in the low bits |
| overflow | output | 1 | Sticky flag for dropped samples |
| cur_desc | output | 2 | Index of the active descriptor |

## Verification
On every cycle the assertions check that a stalled word holds steady, that `overflow` never clears on its own, and that `meta_valid` is a single-cycle pulse. They also check that `out_last` never appears without `out_valid`, and that `cur_desc` moves only in the cycle a record is issued. The values themselves can only be shown by the bench's scenarios. These cover the selected lane or ramp data, the timestamp and count fields, the zero-length record, the truncation split with its dropped samples, and the back-pressure drop, each compared against records the bench builds from its own sample index.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int WORD_W = 32;
  localparam logic [7:0] SYNC_MARK = 8'hC5;
  localparam int REC_WORDS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_META = 2'd2
  } cap_state_t;
endpackage

// File: rtl/cap_sample_clock.sv
module cap_sample_clock #(
  parameter int TSW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_en,
  output logic [TSW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (smp_en) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/cap_src_mux.sv
module cap_src_mux #(
  parameter int W    = 32,
  parameter int NCH  = 4,
  parameter int SELW = 3
) (
  input  logic [NCH*W-1:0] lanes,
  input  logic [W-1:0]     test_word,
  input  logic [SELW-1:0]  sel,
  output logic [W-1:0]     dout
);
  always_comb begin
    dout = test_word;
    for (int i = 0; i < NCH; i++) begin
      if (sel == i[SELW-1:0]) dout = lanes[i*W +: W];
    end
  end
endmodule

// File: rtl/cap_desc_table.sv
module cap_desc_table #(
  parameter int DEPTH = 4,
  parameter int LENW  = 16,
  parameter int IDXW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [LENW-1:0] wlen,
  input  logic [IDXW-1:0] wnext,
  input  logic [IDXW-1:0] rd_idx,
  output logic [LENW-1:0] rd_len,
  output logic [IDXW-1:0] rd_next
);
  logic [LENW-1:0] len_q [DEPTH];
  logic [IDXW-1:0] nxt_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        len_q[i] <= '1;
        nxt_q[i] <= IDXW'((i + 1) % DEPTH);
      end else if (we && waddr == IDXW'(i)) begin
        len_q[i] <= wlen;
        nxt_q[i] <= wnext;
      end
    end
  end

  assign rd_len  = len_q[rd_idx];
  assign rd_next = nxt_q[rd_idx];
endmodule

// File: rtl/gate_capture_packer.sv
module gate_capture_packer
  import cap_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int DESC_DEPTH = 4,
  parameter int LENW       = 16,
  parameter int SELW       = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           smp_en,
  input  logic [NCH*WORD_W-1:0]          ch_data,
  input  logic [SELW-1:0]                src_sel,
  input  logic                           gate,
  input  logic                           hdr_mode,
  input  logic                           desc_we,
  input  logic [$clog2(DESC_DEPTH)-1:0]  desc_waddr,
  input  logic [LENW-1:0]                desc_wlen,
  input  logic [$clog2(DESC_DEPTH)-1:0]  desc_wnext,
  output logic [WORD_W-1:0]              out_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic                           out_last,
  output logic                           meta_valid,
  output logic [REC_WORDS*WORD_W-1:0]    meta_rec,
  output logic                           overflow,
  output logic [$clog2(DESC_DEPTH)-1:0]  cur_desc
);
  localparam int IDXW = $clog2(DESC_DEPTH);
  localparam int TSW  = 2 * WORD_W;

  cap_state_t      st;
  logic [LENW-1:0] cnt;
  logic [TSW-1:0]  ts_q, smp_idx;
  logic [SELW-1:0] src_q, sel_now;
  logic            trunc_q;
  logic [1:0]      widx;
  logic [LENW-1:0] max_len;
  logic [IDXW-1:0] next_link;
  logic [WORD_W-1:0] src_word;
  logic [WORD_W-1:0] rec_w [REC_WORDS];

  cap_sample_clock #(.TSW(TSW)) u_clock (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .idx(smp_idx)
  );

  cap_desc_table #(.DEPTH(DESC_DEPTH), .LENW(LENW), .IDXW(IDXW)) u_desc (
    .clk(clk), .rst_n(rst_n), .we(desc_we), .waddr(desc_waddr),
    .wlen(desc_wlen), .wnext(desc_wnext), .rd_idx(cur_desc),
    .rd_len(max_len), .rd_next(next_link)
  );

  // Control decode for the current cycle
  logic in_open, in_data, close_gate, close_trunc, take, slot_free, acc, drop, trunc_now;
  assign in_open     = (st == ST_IDLE) && gate;
  assign in_data     = (st == ST_DATA) && gate && (cnt != max_len);
  assign close_gate  = (st == ST_DATA) && !gate;
  assign close_trunc = (st == ST_DATA) && gate && (cnt == max_len);
  assign take        = (in_open || in_data) && smp_en;
  assign slot_free   = !out_valid || out_ready;
  assign acc         = take && slot_free;
  assign drop        = (take && !slot_free) || (close_trunc && smp_en)
                     || ((st == ST_META) && gate && smp_en);
  assign trunc_now   = (st == ST_META) ? trunc_q : close_trunc;
  assign sel_now     = in_open ? src_sel : src_q;

  cap_src_mux #(.W(WORD_W), .NCH(NCH), .SELW(SELW)) u_mux (
    .lanes(ch_data), .test_word(smp_idx[WORD_W-1:0]), .sel(sel_now), .dout(src_word)
  );

  always_comb begin
    rec_w[0] = {SYNC_MARK, 7'd0, trunc_now, 16'(src_q)};
    rec_w[1] = ts_q[WORD_W-1:0];
    rec_w[2] = ts_q[TSW-1:WORD_W];
    rec_w[3] = WORD_W'(cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      ts_q       <= '0;
      src_q      <= '0;
      trunc_q    <= 1'b0;
      widx       <= '0;
      cur_desc   <= '0;
      overflow   <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_last   <= 1'b0;
      meta_valid <= 1'b0;
      meta_rec   <= '0;
    end else begin
      meta_valid <= 1'b0;
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
      if (drop) overflow <= 1'b1;

      unique case (st)
        ST_IDLE: if (gate) begin
          st    <= ST_DATA;
          ts_q  <= smp_idx;
          src_q <= src_sel;
          cnt   <= acc ? LENW'(1) : '0;
        end
        ST_DATA: begin
          if (close_gate || close_trunc) begin
            trunc_q <= close_trunc;
            if (hdr_mode) begin
              meta_valid <= 1'b1;
              meta_rec   <= {rec_w[3], rec_w[2], rec_w[1], rec_w[0]};
              cur_desc   <= next_link;
              st         <= ST_IDLE;
            end else begin
              widx <= '0;
              st   <= ST_META;
            end
          end else if (acc) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_META: if (slot_free) begin
          out_valid <= 1'b1;
          out_data  <= rec_w[widx];
          out_last  <= (widx == 2'd3);
          widx      <= widx + 1'b1;
          if (widx == 2'd3) begin
            cur_desc <= next_link;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (acc) begin
        out_valid <= 1'b1;
        out_data  <= src_word;
        out_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            out_valid,
  input logic            out_ready,
  input logic [31:0]     out_data,
  input logic            out_last,
  input logic            meta_valid,
  input logic            overflow,
  input logic [IDXW-1:0] cur_desc
);
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r9_meta_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    meta_valid |=> !meta_valid);

  a_r3_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r7_link_on_record: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_desc) |-> (meta_valid || (out_valid && out_last)));
endmodule

bind gate_capture_packer cap_checker #(.IDXW(IDXW)) u_cap_checker (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .meta_valid(meta_valid),
  .overflow(overflow), .cur_desc(cur_desc)
);

// File: tb/test_gate_capture_packer.sv
module test_gate_capture_packer;
  logic         clk = 1'b0;
  logic         rst_n, smp_en, gate, hdr_mode, desc_we, out_ready;
  logic [127:0] ch_data;
  logic [2:0]   src_sel;
  logic [1:0]   desc_waddr, desc_wnext, cur_desc;
  logic [15:0]  desc_wlen;
  logic [31:0]  out_data;
  logic         out_valid, out_last, meta_valid, overflow;
  logic [127:0] meta_rec;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] idx;
  int exp_cur;
  logic [32:0]  got_q[$], exp_q[$];
  logic [127:0] gmeta_q[$], emeta_q[$];

  always #10 clk = ~clk;

  gate_capture_packer i_gate_capture_packer (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ch_data(ch_data), .src_sel(src_sel),
    .gate(gate), .hdr_mode(hdr_mode), .desc_we(desc_we), .desc_waddr(desc_waddr),
    .desc_wlen(desc_wlen), .desc_wnext(desc_wnext), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .meta_valid(meta_valid), .meta_rec(meta_rec), .overflow(overflow), .cur_desc(cur_desc)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) got_q.push_back({out_last, out_data});
      if (meta_valid) gmeta_q.push_back(meta_rec);
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rec(input logic [2:0] src, input bit tr,
                                       input logic [63:0] ts, input int cnt);
    return {32'(cnt), ts[63:32], ts[31:0], {8'hC5, 7'd0, tr, 13'd0, src}};
  endfunction

  task automatic push_rec(input logic [127:0] r);
    exp_q.push_back({1'b0, r[31:0]});
    exp_q.push_back({1'b0, r[63:32]});
    exp_q.push_back({1'b0, r[95:64]});
    exp_q.push_back({1'b1, r[127:96]});
  endtask

  // Drive one cycle; v is the word source vsel would give, ix the sample index.
  task automatic step(input bit g, input bit s, input logic [2:0] sel, input logic [2:0] vsel,
                      output logic [31:0] v, output logic [63:0] ix);
    @(negedge clk);
    gate = g; smp_en = s; src_sel = sel;
    for (int k = 0; k < 4; k++) ch_data[k*32 +: 32] = $urandom;
    ix = idx;
    v = (vsel >= 3'd4) ? idx[31:0] : ch_data[32*int'(vsel) +: 32];
    if (s) idx = idx + 1;
  endtask

  task automatic idle(input int n);
    logic [31:0] v; logic [63:0] ix;
    for (int c = 0; c < n; c++) step(1'b0, 1'($urandom % 2), 3'($urandom % 5), 3'd0, v, ix);
  endtask

  task automatic cmp(input string tag);
    logic [32:0] e;
    logic [127:0] m;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      if (got_q.size() == 0) chk({tag, " missing word"}, 128'hX, 128'(e));
      else chk(tag, 128'(got_q.pop_front()), 128'(e));
    end
    chk({tag, " extra words"}, 128'(got_q.size()), 128'd0);
    while (emeta_q.size() > 0) begin
      m = emeta_q.pop_front();
      if (gmeta_q.size() == 0) chk("R9 missing meta", 128'hX, m);
      else chk("R9 meta record", gmeta_q.pop_front(), m);
    end
    chk("R9 extra meta", 128'(gmeta_q.size()), 128'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; gate = 1'b0; smp_en = 1'b0; src_sel = '0; hdr_mode = 1'b0;
    desc_we = 1'b0; desc_waddr = '0; desc_wlen = '0; desc_wnext = '0;
    out_ready = 1'b1; ch_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idx = '0; exp_cur = 0;
    got_q.delete(); exp_q.delete(); gmeta_q.delete(); emeta_q.delete();
  endtask

  // Random burst; src_sel changes after the opening cycle must be ignored (R1).
  task automatic burst(input int glen, input int prob);
    logic [2:0] s0; logic [31:0] v; logic [63:0] ix, ts0; int n; bit s;
    s0 = 3'($urandom % 5); n = 0; ts0 = '0;
    for (int c = 0; c < glen; c++) begin
      s = (($urandom % 100) < prob);
      step(1'b1, s, (c == 0) ? s0 : 3'($urandom % 5), s0, v, ix);
      if (c == 0) ts0 = ix;
      if (s) begin exp_q.push_back({1'b0, v}); n++; end
    end
    if (hdr_mode) emeta_q.push_back(rec(s0, 1'b0, ts0, n));
    else push_rec(rec(s0, 1'b0, ts0, n));
    idle(10);
    exp_cur = (exp_cur + 1) % 4;
    cmp("R1 R2 R3 R4 R5 stream");
    chk("R7 cur_desc", 128'(cur_desc), 128'(exp_cur));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v; logic [63:0] ix, ix0;
    logic [31:0] vals [11];
    void'($urandom(32'h5EED));
    do_reset();
    @(negedge clk);
    chk("R10 out_valid", 128'(out_valid), 128'd0);
    chk("R10 meta_valid", 128'(meta_valid), 128'd0);
    chk("R10 overflow", 128'(overflow), 128'd0);
    chk("R10 cur_desc", 128'(cur_desc), 128'd0);
    chk("R10 out_last", 128'(out_last), 128'd0);

    // R5: gate with no samples gives a zero-count record
    burst(3, 0);
    // Random bursts in trailer mode
    for (int b = 0; b < 16; b++) burst(1 + int'($urandom % 12), 70);
    // R9: header mode
    hdr_mode = 1'b1;
    for (int b = 0; b < 3; b++) burst(2 + int'($urandom % 6), 80);
    hdr_mode = 1'b0;

    // R8: back-pressure drops samples and holds the stalled word
    do_reset();
    out_ready = 1'b0;
    step(1'b1, 1'b1, 3'd1, 3'd1, v, ix0);
    vals[0] = v;
    step(1'b1, 1'b1, 3'd1, 3'd1, v, ix);
    step(1'b1, 1'b1, 3'd1, 3'd1, v, ix);
    step(1'b0, 1'b0, 3'd1, 3'd1, v, ix);
    idle(3);
    @(negedge clk);
    chk("R8 overflow set", 128'(overflow), 128'd1);
    chk("R8 stalled valid", 128'(out_valid), 128'd1);
    chk("R8 stalled data", 128'(out_data), 128'(vals[0]));
    out_ready = 1'b1;
    exp_q.push_back({1'b0, vals[0]});
    push_rec(rec(3'd1, 1'b0, ix0, 1));
    idle(12);
    cmp("R8 stream after stall");
    chk("R8 overflow sticky", 128'(overflow), 128'd1);

    // R6: maximum length truncation and continuation under the next descriptor
    do_reset();
    @(negedge clk); desc_we = 1'b1; desc_waddr = 2'd0; desc_wlen = 16'd3; desc_wnext = 2'd1;
    @(negedge clk); desc_waddr = 2'd1; desc_wnext = 2'd2;
    @(negedge clk); desc_we = 1'b0;
    for (int c = 0; c < 11; c++) begin
      step(1'b1, 1'b1, 3'd2, 3'd2, v, ix);
      vals[c] = v;
    end
    step(1'b0, 1'b0, 3'd2, 3'd2, v, ix);
    for (int c = 0; c < 3; c++) exp_q.push_back({1'b0, vals[c]});
    push_rec(rec(3'd2, 1'b1, 64'd0, 3));
    for (int c = 8; c < 11; c++) exp_q.push_back({1'b0, vals[c]});
    push_rec(rec(3'd2, 1'b0, 64'd8, 3));
    idle(12);
    cmp("R6 truncated split");
    chk("R7 linked descriptor", 128'(cur_desc), 128'd2);
    chk("R6 overflow on drops", 128'(overflow), 128'd1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule